// File: doc/BRIEF.md
# Stop-Mode Port-Edge Reset Generator

This block watches an 8-bit input port while the device sits in its clock-stopped low-power state. When any pin of that port moves away from the level it held on entry to that state, in either direction, the block raises a system reset request. The same event pulses a stop-release signal, which tells the power controller to leave the low-power state. The block runs from a free-running low-speed sampling clock, which keeps toggling while the main oscillator is frozen.

The request is a full reset and not an interrupt. It does not depend on the global interrupt enable, and it has no part in interrupt levels, vectors or priorities, so none of those reach the block. Port edges seen in the running or idle state are ignored. After one reset pulse the detector stays silent until the mode input has left the low-power state and entered it again.

Top module: `stop_wake_reset_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `rst_req` and `stop_release` are 0.
- R2: In stop mode (`pwr_mode` = 2'b10), after arming, a rising edge on any single pin sets `rst_req` on the third rising clock edge after the pin change: two synchronizer stages, then one detection register.
- R3: A falling edge on any single pin in armed stop mode triggers with the same latency as R2.
- R4: Once set, `rst_req` stays high for exactly `PULSE_LEN` (default 16) clock cycles and then returns to 0.
- R5: `stop_release` is high for exactly one cycle, the first cycle in which `rst_req` is high, and at no other time.
- R6: In running mode (2'b00) and idle mode (2'b01), pin edges never raise `rst_req`.
- R7: The detector arms on the first clock edge at which `pwr_mode` is stop. The synchronized pin levels captured on that edge are the reference that later pin levels are compared against.
- R8: After a reset pulse, pin edges are ignored while `pwr_mode` stays stop. The detector re-arms only after `pwr_mode` has left stop and entered it again.
- R9: Pin changes made outside stop mode do not trigger after stop is entered. The new levels become the reference.
- R10: The reserved mode code 2'b11 counts as not stop: edges are ignored and the detector is disarmed.
- R11: Several pins changing in the same cycle produce one reset pulse.
- R12: If `pwr_mode` leaves stop on the same clock edge at which a synchronized pin change reaches the comparator, no reset is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running low-speed sampling clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| port_pins | input | PORT_W | Watched port pins; asynchronous to clk |
| pwr_mode | input | 2 | Power state: 00 run, 01 idle, 10 stop, 11 reserved |
| rst_req | output | 1 | Registered system reset request, `PULSE_LEN` cycles long |
| stop_release | output | 1 | Registered one-cycle request to leave stop mode |

## Verification
Two functions can fall on the same clock edge: disarming, when the mode leaves stop, and firing, when a synchronized pin change reaches the comparator. The bench provokes this by changing a pin and then, two cycles later, driving the mode to run, so that on the third edge the mode has already left stop just as the change arrives. The scoreboard queue receives no expected item for that case. Any rise of the reset request counts as a failure, and so does a reset pulse after the bench re-enters stop with the changed level as the new reference.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic [1:0] {
    MODE_RUN  = 2'b00,
    MODE_IDLE = 2'b01,
    MODE_STOP = 2'b10,
    MODE_RSVD = 2'b11
  } pwr_mode_e;

  typedef enum logic [1:0] {
    ST_DISARMED,
    ST_ARMED,
    ST_FIRING,
    ST_SPENT
  } arm_state_e;
endpackage

// File: rtl/swr_pin_sync.sv
module swr_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= '0;
    else     stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else     stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/swr_edge_cmp.sv
module swr_edge_cmp #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [WIDTH-1:0] pins,
  output logic             differ
);
  logic [WIDTH-1:0] ref_q;

  always_ff @(posedge clk) begin
    if (rst)          ref_q <= '0;
    else if (capture) ref_q <= pins;
  end

  assign differ = |(pins ^ ref_q);

  // R7: on the cycle after a capture, the reference matches the sampled pins
  assert_ref_loaded_R7: assert property (@(posedge clk) disable iff (rst)
    capture |=> (ref_q == $past(pins)));
endmodule

// File: rtl/swr_pulse_timer.sv
module swr_pulse_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int CW = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == LAST_CNT) busy  <= 1'b0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign last = busy && (cnt_q == LAST_CNT);

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt_q <= LAST_CNT));
  assert_pulse_ends_at_last_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && !last) |=> busy);
endmodule

// File: rtl/swr_arm_fsm.sv
module swr_arm_fsm
  import swr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_stop,
  input  logic       differ,
  input  logic       pulse_last,
  output logic       capture,
  output logic       fire,
  output arm_state_e state
);
  arm_state_e state_n;

  always_comb begin
    state_n = state;
    capture = 1'b0;
    fire    = 1'b0;
    unique case (state)
      ST_DISARMED: if (in_stop) begin
        capture = 1'b1;
        state_n = ST_ARMED;
      end
      ST_ARMED: begin
        if (!in_stop) state_n = ST_DISARMED;
        else if (differ) begin
          fire    = 1'b1;
          state_n = ST_FIRING;
        end
      end
      ST_FIRING: if (pulse_last) state_n = ST_SPENT;
      ST_SPENT:  if (!in_stop)   state_n = ST_DISARMED;
      default:   state_n = ST_DISARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_DISARMED;
    else     state <= state_n;
  end

  // R12: leaving stop wins over a change arriving on the same edge
  assert_leave_disarms_R12: assert property (@(posedge clk) disable iff (rst)
    !in_stop |-> !fire);
endmodule

// File: rtl/stop_wake_reset_gen.sv
module stop_wake_reset_gen
  import swr_pkg::*;
#(
  parameter int PORT_W    = 8,
  parameter int SYNC_STG  = 2,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] port_pins,
  input  logic [1:0]        pwr_mode,
  output logic              rst_req,
  output logic              stop_release
);
  logic [PORT_W-1:0] pins_s;
  logic              in_stop, differ, capture, fire, pulse_last;
  arm_state_e        fsm_state;

  assign in_stop = (pwr_mode == MODE_STOP);

  swr_pin_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d_async(port_pins), .q_sync(pins_s));

  swr_edge_cmp #(.WIDTH(PORT_W)) u_cmp (
    .clk(clk), .rst(rst), .capture(capture), .pins(pins_s), .differ(differ));

  swr_arm_fsm u_fsm (
    .clk(clk), .rst(rst), .in_stop(in_stop), .differ(differ),
    .pulse_last(pulse_last), .capture(capture), .fire(fire), .state(fsm_state));

  swr_pulse_timer #(.LEN(PULSE_LEN)) u_timer (
    .clk(clk), .rst(rst), .start(fire), .busy(rst_req), .last(pulse_last));

  always_ff @(posedge clk) begin
    if (rst) stop_release <= 1'b0;
    else     stop_release <= fire;
  end

  assert_release_with_rise_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> stop_release);
  assert_release_single_R5: assert property (@(posedge clk) disable iff (rst)
    stop_release |=> !stop_release);
  assert_fire_only_from_stop_R6: assert property (@(posedge clk) disable iff (rst)
    (!in_stop && !rst_req) |=> !rst_req);
  assert_spent_stays_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (fsm_state == ST_SPENT) |=> !$rose(rst_req));
endmodule

// File: tb/stop_wake_reset_gen_tb.sv
module stop_wake_reset_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE      = 16;
  localparam int LAT        = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] port_pins = 8'h00;
  logic [1:0] pwr_mode  = 2'b00;
  logic       rst_req, stop_release;

  stop_wake_reset_gen #(.PORT_W(8), .SYNC_STG(2), .PULSE_LEN(PULSE)) u_dut (
    .clk(clk), .rst(rst), .port_pins(port_pins), .pwr_mode(pwr_mode),
    .rst_req(rst_req), .stop_release(stop_release));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int cyc; string tag; } exp_t;
  exp_t  exp_q[$];
  int    n_chk = 0, n_fail = 0, cyc = 0, width = 0;
  logic  prev_rr = 1'b0;
  bit    done = 1'b0;
  string ctx = "R1";

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  // monitor: compares observed pulses against queued expectations
  always @(negedge clk) begin
    if (!rst) begin
      if (rst_req && !prev_rr) begin
        if (exp_q.size() == 0) chk(1'b0, {ctx, " unexpected reset"}, 1, 0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(cyc == e.cyc, {e.tag, " rise cycle"}, cyc, e.cyc);
        end
        chk(stop_release == 1'b1, "R5 release with rise", int'(stop_release), 1);
        width = 1;
      end else begin
        if (stop_release) chk(1'b0, "R5 stray release", 1, 0);
        if (rst_req) width++;
        if (!rst_req && prev_rr) chk(width == PULSE, "R4 pulse width", width, PULSE);
      end
      prev_rr = rst_req;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_pins(input logic [7:0] v, input bit expect_rst, input string tag);
    port_pins = v;
    if (expect_rst) begin
      exp_t e;
      e.cyc = cyc + LAT;
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic settle(input string tag);
    step(PULSE + 8);
    chk(exp_q.size() == 0, {tag, " missing pulse"}, exp_q.size(), 0);
  endtask

  initial begin
    step(3);
    chk(rst_req == 0 && stop_release == 0, "R1 in reset", int'(rst_req), 0);
    rst = 1'b0;
    step(1);
    chk(rst_req == 0 && stop_release == 0, "R1 after reset", int'(rst_req), 0);

    ctx = "R6";  pwr_mode = 2'b00; step(2);
    drive_pins(8'h01, 0, "R6"); step(3); drive_pins(8'h00, 0, "R6"); settle("R6");
    pwr_mode = 2'b01; step(2);
    drive_pins(8'h80, 0, "R6"); step(3); drive_pins(8'h00, 0, "R6"); settle("R6");

    ctx = "R10"; pwr_mode = 2'b11; step(2);
    drive_pins(8'h10, 0, "R10"); step(3); drive_pins(8'h00, 0, "R10"); settle("R10");

    ctx = "R2";  pwr_mode = 2'b10; step(4);
    drive_pins(8'h08, 1, "R2 rising pin3"); settle("R2");

    ctx = "R8";
    drive_pins(8'h00, 0, "R8"); step(3); drive_pins(8'hFF, 0, "R8"); settle("R8");
    drive_pins(8'h08, 0, "R8"); step(4);

    ctx = "R3";  pwr_mode = 2'b00; step(3); pwr_mode = 2'b10; step(4);
    drive_pins(8'h00, 1, "R3 falling pin3"); settle("R3");

    ctx = "R9";  pwr_mode = 2'b00; step(2);
    drive_pins(8'h5A, 0, "R9"); step(4);
    pwr_mode = 2'b10; step(6); settle("R9 R7 reference");

    ctx = "R11"; pwr_mode = 2'b00; step(2); pwr_mode = 2'b10; step(4);
    drive_pins(8'hA5, 1, "R11 multi-pin"); settle("R11");

    ctx = "R12"; pwr_mode = 2'b00; step(2); pwr_mode = 2'b10; step(4);
    drive_pins(8'hA4, 0, "R12"); step(2);
    pwr_mode = 2'b00; step(4);
    pwr_mode = 2'b10; step(6); settle("R12 collision");

    ctx = "R7";  drive_pins(8'h24, 1, "R7 armed after re-entry"); settle("R7");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule